// File: doc/BRIEF.md
# Windowed Vertical Countdown Divider

This block produces the vertical output pulse of a 60 Hz video timing chain. A clock enable that fires twice per scan line drives a frame counter, so one count is half a line. A separated vertical sync edge restarts the frame only when it falls inside an acceptance window. When no sync is present, the block keeps producing frame pulses by itself.

There are two modes. Search mode has a wide window and accepts unlocked or non-standard sources. Standard mode has a narrow window around the nominal frame length. If the sync is missing there, the block inserts a pulse at the window's closing edge. Hysteresis counters control entry to and exit from standard mode. A line-lock flag from the horizontal loop forces search mode whenever the line loop is not locked. The outputs are the pulse, the mode and a free-running indicator.

Top module: `vwin_divider`

## Requirements
- R1: While reset is asserted and just after it, `vpulse_out` is 0, `std_mode` is 0 (search) and `free_run` is 1.
- R2: With no sync input and `free_run` at 1 in search mode, a frame starts every 525 enabled ticks. The first start comes on tick index 525 after reset, counting the first tick after reset as index 0.
- R3: Sync is taken as a 0-to-1 change of `vsync_in` seen on an enabled tick. In search mode an edge that arrives when 488 to 576 ticks have passed since the last frame start is accepted, whatever the period. The frame restarts on that tick, and `vpulse_out` rises on the clock after it.
- R4: An edge outside the active window is ignored and produces no pulse. In search mode without `free_run`, a frame with no accepted edge ends by itself after 576 ticks and sets `free_run` to 1.
- R5: In search mode with `line_locked` at 1, the 16th accepted sync in a row whose period lies between 522 and 528 ticks switches `std_mode` to 1. An accepted period outside that range, or a frame that times out, restarts this count.
- R6: In standard mode only edges 522 to 528 ticks after the last start are accepted. If none arrives, a frame start is inserted 528 ticks after the last start.
- R7: Six inserted frames in a row in standard mode return the block to search mode. An accepted sync clears the run.
- R8: A tick with `line_locked` at 0 puts the block into search mode on that tick.
- R9: Each output pulse stays high for exactly 12 enabled ticks.
- R10: `std_mode` and `free_run` are never high together. Outputs change only on clocks that carry an enabled tick.
- R11: Any accepted sync clears `free_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hl_tick | input | 1 | Clock enable, one pulse per half line |
| vsync_in | input | 1 | Separated vertical sync level |
| line_locked | input | 1 | Horizontal loop lock status |
| vpulse_out | output | 1 | Vertical output pulse |
| std_mode | output | 1 | 1 = standard (narrow window) mode, 0 = search |
| free_run | output | 1 | 1 = no sync accepted since the last timeout |

## Verification
A wrong frame counter or window decode shows up at the very next frame. The pulse start moves by whole ticks, or a sync that should be rejected produces a pulse, so a start-time mismatch appears within one period of at most 576 ticks. A fault in the lock-in or miss counter stays hidden for many frames. It appears only as `std_mode` changing one frame early or late, on the 16th good sync or the 6th inserted pulse. For that reason the mode is checked at the frame just before each switch and at the frame of the switch.

// File: rtl/vwd_pkg.sv
package vwd_pkg;
  typedef enum logic {
    MODE_SEARCH   = 1'b0,
    MODE_STANDARD = 1'b1
  } vmode_e;
endpackage

// File: rtl/vwd_sync_edge.sv
module vwd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level_in,
  output logic rise_o
);
  logic prev_q, prev_d;

  always_comb begin
    prev_d = prev_q;
    if (tick) prev_d = level_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise_o = tick && level_in && !prev_q;
endmodule

// File: rtl/vwd_frame_timer.sv
module vwd_frame_timer #(
  parameter int WIDE_OPEN    = 488,
  parameter int WIDE_CLOSE   = 576,
  parameter int NARROW_OPEN  = 522,
  parameter int NARROW_CLOSE = 528,
  parameter int FREE_PERIOD  = 525,
  localparam int CNT_W       = $clog2(WIDE_CLOSE + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic in_wide,
  output logic in_narrow,
  output logic wide_done,
  output logic narrow_done,
  output logic free_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIDE_CLOSE + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (restart)              cnt_d = CNT_W'(1);
      else if (cnt_q < CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign in_wide     = (cnt_q >= CNT_W'(WIDE_OPEN))   && (cnt_q <= CNT_W'(WIDE_CLOSE));
  assign in_narrow   = (cnt_q >= CNT_W'(NARROW_OPEN)) && (cnt_q <= CNT_W'(NARROW_CLOSE));
  assign wide_done   = cnt_q >= CNT_W'(WIDE_CLOSE);
  assign narrow_done = cnt_q >= CNT_W'(NARROW_CLOSE);
  assign free_done   = cnt_q >= CNT_W'(FREE_PERIOD);
endmodule

// File: rtl/vwd_mode_ctrl.sv
module vwd_mode_ctrl
  import vwd_pkg::*;
#(
  parameter int LOCKIN_N  = 16,
  parameter int LOSS_N    = 6,
  localparam int LOCKIN_W = $clog2(LOCKIN_N + 1),
  localparam int LOSS_W   = $clog2(LOSS_N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_rise,
  input  logic pulse_busy,
  input  logic line_locked,
  input  logic in_wide,
  input  logic in_narrow,
  input  logic wide_done,
  input  logic narrow_done,
  input  logic free_done,
  output logic frame_start,
  output logic std_mode,
  output logic free_run
);
  vmode_e              mode_q, mode_d;
  logic [LOCKIN_W-1:0] good_q, good_d;
  logic [LOSS_W-1:0]   miss_q, miss_d;
  logic                fr_q, fr_d;
  logic                accept, timeout;

  always_comb begin
    if (mode_q == MODE_STANDARD) begin
      accept  = sync_rise && !pulse_busy && in_narrow;
      timeout = !accept && narrow_done;
    end else begin
      accept  = sync_rise && !pulse_busy && in_wide;
      timeout = !accept && (fr_q ? free_done : wide_done);
    end
  end

  assign frame_start = tick && (accept || timeout);

  always_comb begin
    mode_d = mode_q;
    good_d = good_q;
    miss_d = miss_q;
    fr_d   = fr_q;
    if (tick) begin
      if (accept)
        fr_d = 1'b0;
      else if (timeout && mode_q == MODE_SEARCH)
        fr_d = 1'b1;

      if (!line_locked) begin
        mode_d = MODE_SEARCH;
        good_d = '0;
        miss_d = '0;
      end else if (mode_q == MODE_SEARCH) begin
        if (accept && in_narrow) begin
          if (good_q == LOCKIN_W'(LOCKIN_N - 1)) begin
            mode_d = MODE_STANDARD;
            good_d = '0;
            miss_d = '0;
          end else if (good_q != LOCKIN_W'(LOCKIN_N)) begin
            good_d = good_q + LOCKIN_W'(1);
          end
        end else if (accept || timeout) begin
          good_d = '0;
        end
      end else begin
        if (accept) begin
          miss_d = '0;
        end else if (timeout) begin
          if (miss_q == LOSS_W'(LOSS_N - 1)) begin
            mode_d = MODE_SEARCH;
            good_d = '0;
            miss_d = '0;
          end else if (miss_q != LOSS_W'(LOSS_N)) begin
            miss_d = miss_q + LOSS_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SEARCH;
      good_q <= '0;
      miss_q <= '0;
      fr_q   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      good_q <= good_d;
      miss_q <= miss_d;
      fr_q   <= fr_d;
    end
  end

  assign std_mode = (mode_q == MODE_STANDARD);
  assign free_run = fr_q;
endmodule

// File: rtl/vwd_pulse_gen.sv
module vwd_pulse_gen #(
  parameter int PULSE_LEN = 12,
  localparam int PW       = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic busy_o
);
  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (tick) begin
      if (start)               left_d = PW'(PULSE_LEN);
      else if (left_q != '0)   left_d = left_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/vwin_divider.sv
module vwin_divider #(
  parameter int WIDE_OPEN    = 488,
  parameter int WIDE_CLOSE   = 576,
  parameter int NARROW_OPEN  = 522,
  parameter int NARROW_CLOSE = 528,
  parameter int FREE_PERIOD  = 525,
  parameter int LOCKIN_N     = 16,
  parameter int LOSS_N       = 6,
  parameter int PULSE_LEN    = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hl_tick,
  input  logic vsync_in,
  input  logic line_locked,
  output logic vpulse_out,
  output logic std_mode,
  output logic free_run
);
  logic sync_rise, frame_start, busy;
  logic in_wide, in_narrow, wide_done, narrow_done, free_done;

  vwd_sync_edge i_edge (
    .clk(clk), .rst_n(rst_n), .tick(hl_tick),
    .level_in(vsync_in), .rise_o(sync_rise)
  );

  vwd_frame_timer #(
    .WIDE_OPEN(WIDE_OPEN), .WIDE_CLOSE(WIDE_CLOSE),
    .NARROW_OPEN(NARROW_OPEN), .NARROW_CLOSE(NARROW_CLOSE),
    .FREE_PERIOD(FREE_PERIOD)
  ) i_timer (
    .clk(clk), .rst_n(rst_n), .tick(hl_tick), .restart(frame_start),
    .in_wide(in_wide), .in_narrow(in_narrow), .wide_done(wide_done),
    .narrow_done(narrow_done), .free_done(free_done)
  );

  vwd_mode_ctrl #(.LOCKIN_N(LOCKIN_N), .LOSS_N(LOSS_N)) i_mode (
    .clk(clk), .rst_n(rst_n), .tick(hl_tick), .sync_rise(sync_rise),
    .pulse_busy(busy), .line_locked(line_locked),
    .in_wide(in_wide), .in_narrow(in_narrow), .wide_done(wide_done),
    .narrow_done(narrow_done), .free_done(free_done),
    .frame_start(frame_start), .std_mode(std_mode), .free_run(free_run)
  );

  vwd_pulse_gen #(.PULSE_LEN(PULSE_LEN)) i_pulse (
    .clk(clk), .rst_n(rst_n), .tick(hl_tick), .start(frame_start),
    .busy_o(busy)
  );

  assign vpulse_out = busy;
endmodule

// File: rtl/vwin_divider_chk.sv
module vwin_divider_chk #(
  parameter int PULSE_LEN = 12
) (
  input logic clk,
  input logic rst_n,
  input logic hl_tick,
  input logic line_locked,
  input logic vpulse_out,
  input logic std_mode,
  input logic free_run
);
  logic [7:0] high_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      high_ticks <= '0;
    else if (!vpulse_out)            high_ticks <= '0;
    else if (hl_tick)                high_ticks <= high_ticks + 8'd1;
  end

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpulse_out) |-> (high_ticks == 8'(PULSE_LEN)));

  // R10
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(std_mode && free_run));

  // R10
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hl_tick |=> ($stable(std_mode) && $stable(free_run) && $stable(vpulse_out)));

  // R8
  unlock_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hl_tick && !line_locked) |=> !std_mode);

  // R3
  rise_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpulse_out) |-> $past(hl_tick));
endmodule

bind vwin_divider vwin_divider_chk #(.PULSE_LEN(PULSE_LEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .line_locked(line_locked),
  .vpulse_out(vpulse_out), .std_mode(std_mode), .free_run(free_run)
);

// File: tb/test_vwin_divider.sv
module test_vwin_divider;
  logic clk = 1'b0;
  logic rst_n, hl_tick, vsync_in, line_locked;
  logic vpulse_out, std_mode, free_run;

  int checks = 0;
  int errors = 0;
  int tn;
  int exp_q[$];
  int sync_q[$];
  int start_t;
  logic prev_p;
  bit done = 0;

  always #5 clk = ~clk;

  vwin_divider i_vwin_divider (
    .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .vsync_in(vsync_in),
    .line_locked(line_locked), .vpulse_out(vpulse_out),
    .std_mode(std_mode), .free_run(free_run)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tn <= 0;
    else if (hl_tick) tn <= tn + 1;
  end

  // monitor: pops expected frame-start ticks as pulses appear
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_p <= 1'b0;
    end else begin
      if (vpulse_out && !prev_p) begin
        start_t = tn - 1;
        if (exp_q.size() == 0) check(0, "R4 unexpected pulse", start_t, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(start_t == e, "R2/R3/R6 start tick", start_t, e);
        end
      end
      if (!vpulse_out && prev_p)
        check((tn - 1) - start_t == 12, "R9 width", (tn - 1) - start_t, 12);
      prev_p <= vpulse_out;
    end
  end

  task automatic do_tick();
    @(negedge clk) hl_tick = 1'b1;
    @(negedge clk) hl_tick = 1'b0;
  endtask

  function automatic bit sync_high(input int t);
    foreach (sync_q[i]) if (t >= sync_q[i] && t < sync_q[i] + 4) return 1'b1;
    return 1'b0;
  endfunction

  task automatic stat(input string req, input int es, input int ef);
    if (es >= 0) check(std_mode == es, req, std_mode, es);
    if (ef >= 0) check(free_run == ef, req, free_run, ef);
    check(!(std_mode && free_run), "R10 exclusive", std_mode + free_run, 1);
  endtask

  initial begin
    #1500000;
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hl_tick = 1'b0; vsync_in = 1'b0; line_locked = 1'b1;
    // driver: expected starts and sync schedule
    exp_q.push_back(525); exp_q.push_back(1050);
    sync_q.push_back(1550); sync_q.push_back(2110); sync_q.push_back(2670);
    sync_q.push_back(3270);
    exp_q.push_back(1550); exp_q.push_back(2110); exp_q.push_back(2670);
    exp_q.push_back(3246); exp_q.push_back(3771);
    for (int k = 0; k < 16; k++) begin
      sync_q.push_back(4296 + 525 * k);
      exp_q.push_back(4296 + 525 * k);
    end
    exp_q.push_back(12699);
    sync_q.push_back(13224); exp_q.push_back(13224);
    for (int k = 1; k <= 6; k++) exp_q.push_back(13224 + 528 * k);
    exp_q.push_back(16968); exp_q.push_back(17493);
    for (int k = 0; k < 16; k++) begin
      sync_q.push_back(18018 + 525 * k);
      exp_q.push_back(18018 + 525 * k);
    end
    exp_q.push_back(26469); exp_q.push_back(26994);

    repeat (3) @(negedge clk);
    // R1 reset state
    check(vpulse_out == 0, "R1 vpulse", vpulse_out, 0);
    check(std_mode == 0, "R1 std_mode", std_mode, 0);
    check(free_run == 1, "R1 free_run", free_run, 1);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(vpulse_out == 0 && free_run == 1, "R1 after release", vpulse_out, 0);

    for (int t = 0; t <= 27100; t++) begin
      vsync_in    = sync_high(t);
      line_locked = !(t == 26000 || t == 26001);
      do_tick();
      case (t)
        600:   stat("R2 free run", 0, 1);
        1550:  stat("R11 accept clears", 0, 0);
        2670:  stat("R3 nonstandard stays search", 0, 0);
        3246:  stat("R4 timeout sets free_run", 0, 1);
        4296:  stat("R11 accept clears", 0, 0);
        11646: stat("R5 15th good sync", 0, 0);
        12171: stat("R5 16th good sync", 1, 0);
        12699: stat("R6 inserted pulse keeps std", 1, 0);
        15864: stat("R7 fifth miss", 1, 0);
        16392: stat("R7 sixth miss", 0, 0);
        16968: stat("R4 timeout sets free_run", 0, 1);
        25893: stat("R5 relock", 1, 0);
        26000: stat("R8 line unlock", 0, 0);
        26469: stat("R4 timeout after unlock", 0, 1);
        default: ;
      endcase
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2/R6 missing pulses", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end
endmodule